// File: doc/BRIEF.md
# Phase Error Lock Detector with Hysteresis

This block watches the phase error that a synthesizer loop's phase detector measures once per comparison cycle. Each measurement arrives as an unsigned magnitude, counted in fast-clock cycles, together with a one-cycle valid strobe. The block raises an active-high lock flag once enough consecutive measurements fall under a tight threshold. It drops the flag as soon as a single measurement exceeds a second, looser threshold.

The required run of good measurements is either short (3) or long (5), chosen by a mode input. The two thresholds are run-time inputs, so the same hardware serves any fast-clock rate. For example, a 1 GHz counting clock uses 15 and 25 for limits of 15 ns and 25 ns.

Because the acquire limit is tighter than the release limit, the flag shows hysteresis. A locked loop whose error wanders into the band between the limits stays locked. That band does not count toward anything.

Top module: `phase_lock_monitor`

## Requirements
- R1: While reset is asserted and after it is released, `locked` is 0 and the good-run count is zero.
- R2: With `long_run`=0, `locked` rises in the cycle after the third consecutive valid sample whose `err_mag` is strictly below `tight_lim`.
- R3: With `long_run`=1, `locked` rises in the cycle after the fifth such consecutive valid sample, and not after the fourth.
- R4: While unlocked, a valid sample with `err_mag` >= `tight_lim` resets the run, so a complete new run is required.
- R5: While locked, a single valid sample with `err_mag` strictly above `loose_lim` clears `locked` in the next cycle.
- R6: While locked, a valid sample with `tight_lim` <= `err_mag` <= `loose_lim` leaves `locked` high.
- R7: Cycles with `err_valid`=0 change neither `locked` nor the run, whatever `err_mag` holds. Gaps may occur inside a run.
- R8: After lock is lost, the run restarts from zero, so one good sample alone does not relock.
- R9: A sample exactly equal to `loose_lim` does not clear lock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| err_valid | input | 1 | One-cycle strobe marking a new phase-error sample |
| err_mag | input | ERR_W | Phase-error magnitude in fast-clock cycles |
| long_run | input | 1 | 0: need SHORT_RUN good samples; 1: need LONG_RUN |
| tight_lim | input | ERR_W | Acquire threshold; good means strictly below it |
| loose_lim | input | ERR_W | Release threshold; bad means strictly above it |
| locked | output | 1 | Lock flag, active high |

## Verification
The hardest case to reach from the ports is a run that broke partway. A mutant that failed to clear a partial run, or that counted band samples, would only show up when a later run reaches its target too early. The stimulus therefore builds runs that stop one sample short, breaks them with values exactly at `tight_lim` or inside the hysteresis band, and then counts the samples needed to relock. Idle cycles that carry large error values are mixed in. A pseudo-random stretch in both modes then compares every cycle against a reference model.

// File: rtl/plm_pkg.sv
package plm_pkg;

   // Classification of one phase-detector sample
   typedef struct packed {
      logic valid;   // sample present this cycle
      logic good;    // strictly below the acquire threshold
      logic bad;     // strictly above the release threshold
   } err_class_t;

endpackage

// File: rtl/plm_classifier.sv
module plm_classifier
   import plm_pkg::*;
#(
   parameter int ERR_W      = 8,
   parameter bit REGISTERED = 1'b0
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             err_valid,
   input  logic [ERR_W-1:0] err_mag,
   input  logic [ERR_W-1:0] tight_lim,
   input  logic [ERR_W-1:0] loose_lim,
   output err_class_t       cls
);

   err_class_t cls_d;

   always_comb begin
      cls_d.valid = err_valid;
      cls_d.good  = err_valid && (err_mag < tight_lim);
      cls_d.bad   = err_valid && (err_mag > loose_lim);
   end

   generate
      if (REGISTERED) begin : g_reg
         err_class_t cls_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) cls_q <= '0;
            else        cls_q <= cls_d;
         end
         assign cls = cls_q;
      end else begin : g_comb
         assign cls = cls_d;
      end
   endgenerate

endmodule

// File: rtl/plm_run_counter.sv
module plm_run_counter
   import plm_pkg::*;
#(
   parameter int SHORT_RUN = 3,
   parameter int LONG_RUN  = 5,
   parameter int CNT_W     = 3
) (
   input  logic             clk,
   input  logic             rst_n,
   input  err_class_t       cls,
   input  logic             locked,
   input  logic             long_run,
   output logic             reach,
   output logic [CNT_W-1:0] run_cnt
);

   localparam logic [CNT_W:0] NEED_S = (CNT_W+1)'(SHORT_RUN);
   localparam logic [CNT_W:0] NEED_L = (CNT_W+1)'(LONG_RUN);

   logic [CNT_W:0] next_run;
   logic [CNT_W:0] need;

   always_comb begin
      need     = long_run ? NEED_L : NEED_S;
      next_run = {1'b0, run_cnt} + (CNT_W+1)'(1);
      reach    = !locked && cls.valid && cls.good && (next_run >= need);
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         run_cnt <= '0;
      end else if (locked || reach) begin
         run_cnt <= '0;
      end else if (cls.valid) begin
         run_cnt <= cls.good ? next_run[CNT_W-1:0] : '0;
      end
   end

endmodule

// File: rtl/plm_lock_flag.sv
module plm_lock_flag
   import plm_pkg::*;
(
   input  logic       clk,
   input  logic       rst_n,
   input  err_class_t cls,
   input  logic       reach,
   output logic       locked
);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         locked <= 1'b0;
      end else if (locked) begin
         if (cls.valid && cls.bad) locked <= 1'b0;
      end else if (reach) begin
         locked <= 1'b1;
      end
   end

endmodule

// File: rtl/phase_lock_monitor.sv
module phase_lock_monitor
   import plm_pkg::*;
#(
   parameter int ERR_W      = 8,
   parameter int SHORT_RUN  = 3,
   parameter int LONG_RUN   = 5,
   parameter bit REG_CLASS  = 1'b0
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             err_valid,
   input  logic [ERR_W-1:0] err_mag,
   input  logic             long_run,
   input  logic [ERR_W-1:0] tight_lim,
   input  logic [ERR_W-1:0] loose_lim,
   output logic             locked
);

   localparam int CNT_W = (LONG_RUN < 2) ? 1 : $clog2(LONG_RUN);

   generate
      if (ERR_W < 1) begin : g_bad_w
         $error("ERR_W must be at least 1");
      end
      if (SHORT_RUN < 1) begin : g_bad_s
         $error("SHORT_RUN must be at least 1");
      end
      if (LONG_RUN < SHORT_RUN) begin : g_bad_l
         $error("LONG_RUN must not be below SHORT_RUN");
      end
   endgenerate

   err_class_t       cls;
   logic             reach;
   logic [CNT_W-1:0] run_cnt;

   plm_classifier #(.ERR_W(ERR_W), .REGISTERED(REG_CLASS)) u_class (
      .clk(clk), .rst_n(rst_n), .err_valid(err_valid), .err_mag(err_mag),
      .tight_lim(tight_lim), .loose_lim(loose_lim), .cls(cls)
   );

   plm_run_counter #(.SHORT_RUN(SHORT_RUN), .LONG_RUN(LONG_RUN), .CNT_W(CNT_W)) u_run (
      .clk(clk), .rst_n(rst_n), .cls(cls), .locked(locked),
      .long_run(long_run), .reach(reach), .run_cnt(run_cnt)
   );

   plm_lock_flag u_flag (
      .clk(clk), .rst_n(rst_n), .cls(cls), .reach(reach), .locked(locked)
   );

endmodule

// File: rtl/plm_checker.sv
module plm_checker #(
   parameter int SHORT_RUN = 3,
   parameter int LONG_RUN  = 5,
   parameter int CNT_W     = 3
) (
   input logic             clk,
   input logic             rst_n,
   input logic             cls_valid,
   input logic             cls_good,
   input logic             cls_bad,
   input logic [CNT_W-1:0] run_cnt,
   input logic             locked
);

   localparam logic [CNT_W-1:0] MIN_BEFORE = CNT_W'(SHORT_RUN - 1);
   localparam logic [CNT_W-1:0] MAX_RUN    = CNT_W'(LONG_RUN - 1);

   AST_RISE_AFTER_RUN: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(locked) |-> $past(cls_valid && cls_good && run_cnt >= MIN_BEFORE)); // R2
   AST_RUN_BOUNDED: assert property (@(posedge clk) disable iff (!rst_n)
      run_cnt <= MAX_RUN); // R3
   AST_FALL_ON_BAD: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(locked) |-> $past(cls_valid && cls_bad)); // R5
   AST_HOLD_LOCK: assert property (@(posedge clk) disable iff (!rst_n)
      locked && !(cls_valid && cls_bad) |=> locked); // R6
   AST_IDLE_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
      !cls_valid && !locked |=> $stable(run_cnt) && !locked); // R7
   AST_RUN_CLEAR_LOCKED: assert property (@(posedge clk) disable iff (!rst_n)
      locked |-> run_cnt == '0); // R8

endmodule

bind phase_lock_monitor plm_checker #(
   .SHORT_RUN(SHORT_RUN), .LONG_RUN(LONG_RUN), .CNT_W(CNT_W)
) chk (
   .clk(clk), .rst_n(rst_n), .cls_valid(cls.valid), .cls_good(cls.good),
   .cls_bad(cls.bad), .run_cnt(run_cnt), .locked(locked)
);

// File: tb/phase_lock_monitor_test.sv
module phase_lock_monitor_test;

   localparam int W = 8;

   logic         clk = 1'b0;
   logic         rst_n = 1'b0;
   logic         err_valid = 1'b0;
   logic [W-1:0] err_mag = '0;
   logic         long_run = 1'b0;
   logic [W-1:0] tight_lim = 8'd15;
   logic [W-1:0] loose_lim = 8'd25;
   logic         locked;

   int total = 0;
   int bad = 0;

   typedef struct { logic exp; string tag; } item_t;
   item_t sb[$];

   // reference model state
   logic m_lock = 1'b0;
   int   m_run  = 0;

   always #5 clk = ~clk;

   phase_lock_monitor #(.ERR_W(W)) uut (
      .clk(clk), .rst_n(rst_n), .err_valid(err_valid), .err_mag(err_mag),
      .long_run(long_run), .tight_lim(tight_lim), .loose_lim(loose_lim),
      .locked(locked)
   );

   task automatic step(input logic v, input int e, input string tag);
      int need;
      @(negedge clk);
      err_valid = v;
      err_mag   = W'(e);
      need = long_run ? 5 : 3;
      if (v) begin
         if (!m_lock) begin
            if (e < int'(tight_lim)) begin
               if (m_run + 1 >= need) begin m_lock = 1'b1; m_run = 0; end
               else m_run = m_run + 1;
            end else m_run = 0;
         end else if (e > int'(loose_lim)) begin
            m_lock = 1'b0; m_run = 0;
         end
      end
      sb.push_back('{m_lock, tag});
   endtask

   // monitor: compares each expected item after the edge that produces it
   always @(posedge clk) begin
      #2;
      if (sb.size() > 0) begin
         item_t it;
         it = sb.pop_front();
         total++;
         if (locked !== it.exp) begin
            bad++;
            $display("FAIL %s: locked=%0b expected=%0b at %0t", it.tag, locked, it.exp, $time);
         end
      end
   end

   initial begin
      repeat (200000) @(posedge clk);
      bad++;
      $display("FAIL watchdog: run did not complete, actual=hung expected=done");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      int lcg;
      // R1: reset state
      repeat (3) @(posedge clk);
      #2;
      total++;
      if (locked !== 1'b0) begin
         bad++;
         $display("FAIL R1: locked=%0b expected=0 in reset", locked);
      end
      @(negedge clk);
      rst_n = 1'b1;
      step(1'b0, 0, "R1");
      step(1'b0, 0, "R1");

      // R2: short run of three
      step(1'b1, 3, "R2");
      step(1'b1, 14, "R2");
      step(1'b1, 0, "R2");
      // R9, R6: boundary and band values keep lock
      step(1'b1, 25, "R9");
      step(1'b1, 20, "R6");
      step(1'b1, 15, "R6");
      // R7: idle with large value while locked
      step(1'b0, 200, "R7");
      // R5: one sample beyond release limit
      step(1'b1, 26, "R5");
      // R8: one good sample after loss is not enough
      step(1'b1, 1, "R8");
      step(1'b1, 1, "R8");
      step(1'b1, 1, "R8");
      step(1'b1, 99, "R5");
      // R4: run broken by value equal to tight limit, and by band value
      step(1'b1, 2, "R4");
      step(1'b1, 2, "R4");
      step(1'b1, 15, "R4");
      step(1'b1, 2, "R4");
      step(1'b1, 2, "R4");
      step(1'b1, 20, "R4");
      step(1'b1, 2, "R4");
      step(1'b1, 2, "R4");
      step(1'b1, 2, "R4");
      step(1'b1, 255, "R5");
      // R7: gaps inside a run with large idle values
      step(1'b1, 5, "R7");
      step(1'b0, 250, "R7");
      step(1'b0, 250, "R7");
      step(1'b1, 5, "R7");
      step(1'b0, 250, "R7");
      step(1'b1, 5, "R7");
      step(1'b1, 200, "R5");

      // R3: long run of five
      @(negedge clk); long_run = 1'b1; sb.push_back('{m_lock, "R3"});
      for (int i = 0; i < 5; i++) step(1'b1, 7, "R3");
      step(1'b1, 26, "R5");
      for (int i = 0; i < 4; i++) step(1'b1, 7, "R3");
      step(1'b1, 16, "R3");
      for (int i = 0; i < 5; i++) step(1'b1, 7, "R3");

      // mixed pseudo-random traffic in both modes
      lcg = 12345;
      for (int i = 0; i < 600; i++) begin
         lcg = (lcg * 1103515245 + 12345) & 32'h7fffffff;
         if (i == 300) begin
            @(negedge clk); long_run = 1'b0; sb.push_back('{m_lock, "R2"});
         end
         step(((lcg >> 8) % 4) != 0, (lcg >> 12) % 32, i < 300 ? "R3" : "R2");
      end

      @(negedge clk);
      err_valid = 1'b0;
      repeat (3) @(posedge clk);
      #3;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

endmodule